// File: doc/BRIEF.md
# Register-Mapped Multiply / Divide / Multiply-Accumulate Unit

This block is an arithmetic peripheral reached through a byte-wide register bus. A host writes two 16-bit operands into a 32-bit operand register (the low half and the high half of "A"). The moment the last of its four bytes has been written, the unit multiplies the two halves and places the 32-bit product in the result register "B". In the accumulate modes the product is also added into a 32-bit accumulator "C". Signedness and accumulation are chosen by bits of a control register.

The same registers serve a 32/32 unsigned division. The host loads the dividend into A and the divisor into B. Writing the control register with the divide bit and the start/busy bit both set starts an iterative divider. The busy bit reads back high for a fixed 17 cycles. The quotient then lands in A and the remainder in C, and the busy bit drops. A zero divisor gives all-ones in both results. While a division runs, every register write is dropped.

Top module: `muldiv_mmio`

## Requirements
- R1: After reset every register reads 0x00 at all sixteen byte offsets.
- R2: Registers are little-endian bytes at these offsets: control at 0, A at 4..7, B at 8..11 and C at 12..15. Within A and B, bytes 0..1 form the low half and bytes 2..3 the high half. Offsets 1..3 read 0x00.
- R3: A multiply fires on the clock edge that captures the write completing all four A bytes, in any order. Three bytes alone leave B unchanged.
- R4: The mode is the control value ANDed with 0xC8. For mode 0x00, B becomes the unsigned product of A-low and A-high. For mode 0x08, B becomes the signed product, with each half sign-extended first.
- R5: Mode 0x40 (unsigned) and mode 0x48 (signed) also write the product to B, and set C to C plus the product, modulo 2^32.
- R6: Once a multiply fires, the byte tracker clears. A later multiply needs all four A bytes to be written again.
- R7: A control write with bit 7 and bit 0 both set starts a division. Control bit 0 then reads 1 for exactly 17 cycles after the capturing edge and reads 0 afterwards. Writing bit 0 without bit 7 leaves bit 0 at 0. While bit 7 is set, completing A fires no multiply.
- R8: A division takes A as the dividend and B as the divisor. It writes the quotient to A and the remainder to C, and leaves B unchanged.
- R9: A division by zero writes 0xFFFFFFFF to both A and C.
- R10: While a division is busy, writes to every register, control included, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Byte offset of the register access |
| wr_en | input | 1 | Write strobe, captured on the rising edge |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte for `addr`, combinational |

## Verification
The assertions check, on every cycle, the behaviours that follow from the divider's state alone. Busy stays high until the step count is complete and drops right after the writeback cycle. A and B stay frozen while a division runs. A zero divisor leaves all-ones in A and C. The byte tracker is empty after each multiply fires. The arithmetic itself can only be shown by the bench's scenarios: products in each of the four modes, accumulator wrap, and quotient and remainder values. So can the exact 17-cycle busy window seen at the bus, the ignored bit-0 writes, and the effect of byte order on when a multiply fires.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
    // Register blocks, selected by the two top address bits
    typedef enum logic [1:0] {
        BLK_CTRL = 2'd0,
        BLK_A    = 2'd1,
        BLK_B    = 2'd2,
        BLK_C    = 2'd3
    } blk_e;

    // Control-register field positions
    localparam int CTL_DIV_BIT  = 7;
    localparam int CTL_ACC_BIT  = 6;
    localparam int CTL_SGN_BIT  = 3;

    // Mode selection: control ANDed with this mask
    localparam logic [7:0] MODE_MASK = 8'hC8;
    localparam logic [7:0] MODE_UMUL = 8'h00;
    localparam logic [7:0] MODE_SMUL = 8'h08;
    localparam logic [7:0] MODE_UMAC = 8'h40;
    localparam logic [7:0] MODE_SMAC = 8'h48;
endpackage

// File: rtl/muldiv_byte_track.sv
module muldiv_byte_track #(
    parameter int NBYTES = 4,
    localparam int IDX_W = $clog2(NBYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_wr,
    input  logic [IDX_W-1:0] byte_idx,
    output logic             fire
);
    logic [NBYTES-1:0] seen_d, seen_q;
    logic [NBYTES-1:0] seen_new;

    always_comb begin
        seen_new = seen_q | (NBYTES'(1) << byte_idx);
        fire     = byte_wr && (seen_new == '1);
        seen_d   = seen_q;
        if (fire) begin
            seen_d = '0;
        end else if (byte_wr) begin
            seen_d = seen_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else begin
            seen_q <= seen_d;
        end
    end

    // R6: after a multiply fires the tracker is empty
    assert_fire_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (seen_q == '0));
endmodule

// File: rtl/muldiv_mult.sv
module muldiv_mult #(
    parameter int OP_W = 16,
    localparam int RES_W = 2 * OP_W
) (
    input  logic [OP_W-1:0]  op_lo,
    input  logic [OP_W-1:0]  op_hi,
    input  logic             is_signed,
    input  logic [RES_W-1:0] acc_in,
    output logic [RES_W-1:0] product,
    output logic [RES_W-1:0] acc_sum
);
    logic signed [OP_W:0] ext_lo, ext_hi;

    always_comb begin
        ext_lo  = {is_signed & op_lo[OP_W-1], op_lo};
        ext_hi  = {is_signed & op_hi[OP_W-1], op_hi};
        product = RES_W'(ext_lo * ext_hi);
        acc_sum = acc_in + product;
    end
endmodule

// File: rtl/muldiv_divider.sv
module muldiv_divider #(
    parameter int DATA_W = 32,
    parameter int BITS_PER_STEP = 2,
    localparam int STEPS = DATA_W / BITS_PER_STEP,
    localparam int CNT_W = $clog2(STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] dividend,
    input  logic [DATA_W-1:0] divisor,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] quotient,
    output logic [DATA_W-1:0] remainder
);
    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] quo;
        logic [DATA_W-1:0] rem;
        logic [DATA_W-1:0] dvs;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [DATA_W:0]   trial;
    logic [DATA_W-1:0] q_w, r_w;
    logic              last_step;

    always_comb begin
        st_d      = st_q;
        last_step = (st_q.cnt == CNT_W'(STEPS));
        done      = st_q.busy && last_step;
        q_w       = st_q.quo;
        r_w       = st_q.rem;
        trial     = '0;
        if (start && !st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.quo  = dividend;
            st_d.rem  = '0;
            st_d.dvs  = divisor;
        end else if (st_q.busy) begin
            if (last_step) begin
                st_d.busy = 1'b0;
            end else begin
                for (int k = 0; k < BITS_PER_STEP; k++) begin
                    trial = {r_w, q_w[DATA_W-1]};
                    q_w   = {q_w[DATA_W-2:0], 1'b0};
                    if (trial >= {1'b0, st_q.dvs}) begin
                        trial  = trial - {1'b0, st_q.dvs};
                        q_w[0] = 1'b1;
                    end
                    r_w = trial[DATA_W-1:0];
                end
                st_d.quo = q_w;
                st_d.rem = r_w;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        busy = st_q.busy;
        if (st_q.dvs == '0) begin
            quotient  = '1;
            remainder = '1;
        end else begin
            quotient  = st_q.quo;
            remainder = st_q.rem;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: busy holds until every step has run
    assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !last_step) |=> st_q.busy);
    // R7: busy drops right after the writeback cycle
    assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !st_q.busy);
endmodule

// File: rtl/muldiv_mmio.sv
module muldiv_mmio
    import muldiv_pkg::*;
#(
    parameter int OP_W = 16,
    parameter int DIV_BITS_PER_STEP = 2,
    localparam int RES_W = 2 * OP_W,
    localparam int NBYTES = RES_W / 8,
    localparam int IDX_W = $clog2(NBYTES),
    localparam int ADDR_W = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data
);
    typedef struct packed {
        logic [7:0]       ctrl;
        logic [RES_W-1:0] a;
        logic [RES_W-1:0] b;
        logic [RES_W-1:0] c;
    } regs_t;

    regs_t st_d, st_q;

    blk_e             blk;
    logic [IDX_W-1:0] idx;
    logic             wr_ok;
    logic [RES_W-1:0] a_new;
    logic [7:0]       mode;
    logic             mul_fire;
    logic [RES_W-1:0] prod, acc_sum;
    logic             div_start, div_busy, div_done;
    logic [RES_W-1:0] div_q, div_r;

    function automatic logic [RES_W-1:0] put_byte(input logic [RES_W-1:0] w,
                                                  input logic [IDX_W-1:0] i,
                                                  input logic [7:0] v);
        logic [RES_W-1:0] r;
        r = w;
        r[i*8 +: 8] = v;
        return r;
    endfunction

    function automatic logic [7:0] get_byte(input logic [RES_W-1:0] w,
                                            input logic [IDX_W-1:0] i);
        return w[i*8 +: 8];
    endfunction

    muldiv_byte_track #(.NBYTES(NBYTES)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_wr  (wr_ok && (blk == BLK_A)),
        .byte_idx (idx),
        .fire     (mul_fire)
    );

    muldiv_mult #(.OP_W(OP_W)) u_mult (
        .op_lo     (a_new[OP_W-1:0]),
        .op_hi     (a_new[RES_W-1:OP_W]),
        .is_signed (st_q.ctrl[CTL_SGN_BIT]),
        .acc_in    (st_q.c),
        .product   (prod),
        .acc_sum   (acc_sum)
    );

    muldiv_divider #(.DATA_W(RES_W), .BITS_PER_STEP(DIV_BITS_PER_STEP)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (div_start),
        .dividend  (st_q.a),
        .divisor   (st_q.b),
        .busy      (div_busy),
        .done      (div_done),
        .quotient  (div_q),
        .remainder (div_r)
    );

    always_comb begin
        st_d      = st_q;
        blk       = blk_e'(addr[ADDR_W-1 -: 2]);
        idx       = addr[IDX_W-1:0];
        wr_ok     = wr_en && !div_busy;
        mode      = st_q.ctrl & MODE_MASK;
        div_start = 1'b0;

        a_new = st_q.a;
        if (wr_ok && blk == BLK_A) begin
            a_new = put_byte(st_q.a, idx, wr_data);
        end
        st_d.a = a_new;

        if (wr_ok) begin
            unique case (blk)
                BLK_CTRL: begin
                    if (idx == '0) begin
                        st_d.ctrl = {wr_data[7:1], 1'b0};
                        div_start = wr_data[CTL_DIV_BIT] & wr_data[0];
                    end
                end
                BLK_B:   st_d.b = put_byte(st_q.b, idx, wr_data);
                BLK_C:   st_d.c = put_byte(st_q.c, idx, wr_data);
                default: ;
            endcase
        end

        if (mul_fire) begin
            unique case (mode)
                MODE_UMUL, MODE_SMUL: st_d.b = prod;
                MODE_UMAC, MODE_SMAC: begin
                    st_d.b = prod;
                    st_d.c = acc_sum;
                end
                default: ;
            endcase
        end

        if (div_done) begin
            st_d.a = div_q;
            st_d.c = div_r;
        end

        unique case (blk)
            BLK_CTRL: rd_data = (idx == '0) ? (st_q.ctrl | {7'd0, div_busy}) : 8'h00;
            BLK_A:    rd_data = get_byte(st_q.a, idx);
            BLK_B:    rd_data = get_byte(st_q.b, idx);
            default:  rd_data = get_byte(st_q.c, idx);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R10: operands stay frozen while a division runs
    assert_busy_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (div_busy && !div_done) |=> ($stable(st_q.a) && $stable(st_q.b)));
    // R9: zero divisor leaves all-ones in quotient and remainder
    assert_div_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (div_done && st_q.b == '0) |=> (st_q.a == '1 && st_q.c == '1));
    // R7: a start is only accepted while idle
    assert_start_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        div_start |-> !div_busy);
endmodule

// File: tb/test_muldiv_mmio.sv
module test_muldiv_mmio;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;

    muldiv_mmio i_muldiv_mmio (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [15:0] lo;
        logic [15:0] hi;
        logic [31:0] c0;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'h00, 16'hFFFF, 16'hFFFF, 32'h0},
        '{8'h08, 16'hFFFF, 16'h0002, 32'h0},
        '{8'h08, 16'h8000, 16'h8000, 32'h0},
        '{8'h00, 16'h1234, 16'h0000, 32'h0},
        '{8'h40, 16'h0100, 16'h0100, 32'h5},
        '{8'h48, 16'hFFFF, 16'h0003, 32'h10},
        '{8'h40, 16'hFFFF, 16'hFFFF, 32'hFFFFFFFF},
        '{8'h48, 16'h7FFF, 16'h8000, 32'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wr32(input logic [3:0] base, input logic [31:0] v);
        for (int i = 0; i < 4; i++) wr(base + 4'(i), v[i*8 +: 8]);
    endtask

    task automatic rd32(input logic [3:0] base, output logic [31:0] v);
        logic [7:0] t;
        for (int i = 0; i < 4; i++) begin
            rd(base + 4'(i), t);
            v[i*8 +: 8] = t;
        end
    endtask

    function automatic logic [31:0] mul_exp(input logic sgn, input logic [15:0] x, input logic [15:0] y);
        longint p;
        if (sgn) p = longint'($signed(x)) * longint'($signed(y));
        else     p = longint'(x) * longint'(y);
        return p[31:0];
    endfunction

    task automatic run_div(input string req, input logic [31:0] n, input logic [31:0] d);
        logic [31:0] va, vb, vc, eq, er;
        wr(4'h0, 8'h80);
        wr32(4'h4, n);
        wr32(4'h8, d);
        wr(4'h0, 8'h81);
        repeat (17) @(negedge clk);
        if (d == 0) begin eq = '1; er = '1; end
        else begin eq = n / d; er = n % d; end
        rd32(4'h4, va); rd32(4'h8, vb); rd32(4'hC, vc);
        chk({req, " quotient"}, va, eq);
        chk({req, " remainder"}, vc, er);
        chk({req, " divisor kept"}, vb, d);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  b8;
        logic [31:0] v, v2, eb, ec;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: all offsets zero after reset
        for (int i = 0; i < 16; i++) begin
            rd(4'(i), b8);
            chk("R1 reset value", {24'd0, b8}, 32'd0);
        end

        // R3 R4 R5: table walk; even entries ascending byte order, odd descending
        foreach (VECS[k]) begin
            wr(4'h0, VECS[k].ctrl);
            wr32(4'hC, VECS[k].c0);
            for (int i = 0; i < 4; i++) begin
                int j;
                j = (k % 2 == 0) ? i : 3 - i;
                wr(4'(4 + j), j < 2 ? VECS[k].lo[j*8 +: 8] : VECS[k].hi[(j-2)*8 +: 8]);
            end
            eb = mul_exp(VECS[k].ctrl[3], VECS[k].lo, VECS[k].hi);
            ec = VECS[k].ctrl[6] ? VECS[k].c0 + eb : VECS[k].c0;
            rd32(4'h8, v);
            chk("R4 R5 product in B", v, eb);
            rd32(4'hC, v);
            chk("R5 accumulator C", v, ec);
        end

        // R2: byte layout of A, and unused control offsets
        rd32(4'h4, v);
        chk("R2 A little-endian", v, 32'h8000_7FFF);
        rd(4'h5, b8);
        chk("R2 A byte 1", {24'd0, b8}, 32'h7F);
        rd(4'h1, b8);
        chk("R2 offset 1 reads zero", {24'd0, b8}, 32'd0);

        // R3: three bytes do not fire
        wr(4'h0, 8'h00);
        wr32(4'h8, 32'hA5A5_5A5A);
        wr(4'h4, 8'h03); wr(4'h5, 8'h00); wr(4'h6, 8'h05);
        rd32(4'h8, v);
        chk("R3 no fire after three bytes", v, 32'hA5A5_5A5A);
        wr(4'h7, 8'h00);
        rd32(4'h8, v);
        chk("R3 fire on fourth byte", v, 32'd15);

        // R6: tracker cleared; one more byte write does not fire
        wr(4'h4, 8'h09);
        rd32(4'h8, v);
        chk("R6 tracker cleared", v, 32'd15);
        wr(4'h5, 8'h00); wr(4'h6, 8'h02); wr(4'h7, 8'h00);
        rd32(4'h8, v);
        chk("R6 fires after four new bytes", v, 32'd18);

        // R7: bit 0 alone is not stored; bit 7 set suppresses multiply
        wr(4'h0, 8'h49);
        rd(4'h0, b8);
        chk("R7 bit0 not stored", {24'd0, b8}, 32'h48);
        wr(4'h0, 8'h80);
        wr32(4'h8, 32'h0000_1111);
        wr32(4'h4, 32'h0002_0003);
        rd32(4'h8, v);
        chk("R7 no multiply with bit 7", v, 32'h0000_1111);

        // R7: busy window of exactly 17 cycles
        wr32(4'h4, 32'd100000);
        wr32(4'h8, 32'd7);
        wr(4'h0, 8'h81);
        rd(4'h0, b8);
        chk("R7 busy right after start", {24'd0, b8}, 32'h81);
        repeat (16) @(negedge clk);
        rd(4'h0, b8);
        chk("R7 busy after 17th cycle start", {24'd0, b8}, 32'h81);
        @(negedge clk);
        rd(4'h0, b8);
        chk("R7 busy cleared", {24'd0, b8}, 32'h80);
        // R8: results of that division
        rd32(4'h4, v);
        chk("R8 quotient", v, 32'd14285);
        rd32(4'hC, v);
        chk("R8 remainder", v, 32'd5);
        rd32(4'h8, v);
        chk("R8 divisor kept", v, 32'd7);

        run_div("R8 large", 32'hFFFF_FFFF, 32'h0001_0000);
        run_div("R8 small dividend", 32'd5, 32'd9);
        run_div("R9 divide by zero", 32'h1234_5678, 32'd0);

        // R10: writes ignored while busy
        wr32(4'h4, 32'd1000);
        wr32(4'h8, 32'd10);
        wr32(4'hC, 32'd0);
        wr(4'h0, 8'h81);
        wr(4'h4, 8'hEE);
        wr(4'h8, 8'hEE);
        wr(4'hC, 8'hEE);
        wr(4'h0, 8'h00);
        rd(4'h0, b8);
        chk("R10 control write ignored", {24'd0, b8}, 32'h81);
        repeat (17) @(negedge clk);
        rd32(4'h4, v);
        rd32(4'h8, v2);
        chk("R10 A write ignored", v, 32'd100);
        chk("R10 B write ignored", v2, 32'd10);
        rd32(4'hC, v);
        chk("R10 C write ignored", v, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule